// File: doc/BRIEF.md
# Eight-Input Vectored Priority Interrupt Controller

This block collects eight interrupt request lines, keeps a pending register and an in-service register, and raises one interrupt output to a processor when the most urgent unmasked request may be served. The processor answers with a one-cycle acknowledge pulse. In that cycle the block presents an 8-bit vector, the programmed base plus the input number. On the clock edge that ends the pulse, the request moves from pending to in-service.

Software reaches the block through a small register port. The command address starts an initialization sequence, selects which status register command reads return, and carries numbered end-of-interrupt commands. The data address takes the initialization words and, once those are done, the interrupt mask. A third address holds a per-input trigger selector that picks edge or level sensing. Priority is fixed, with input 0 the most urgent. Cascading is not built. The block only keeps the cascade word and drives it out for neighbouring logic.

Top module: `pic_ctrl`

## Requirements
- R1: After reset the pending and in-service registers are zero, the mask is 0xFF, the trigger selector is 0x00 (all edge), irq_out is low, and command-address reads return the pending register.
- R2: A command-address (bus_addr 0) write with bit 4 set starts initialization. It clears the in-service register, clears automatic end-of-interrupt and selects pending readback. The next data-address (bus_addr 1) writes are taken as the vector base, then the cascade word, then the mode word. The mode word is expected only if bit 0 of the start word was set.
- R3: Outside initialization, a data-address write loads the mask, where a 1 blocks that input. A data-address read returns the mask. Initialization leaves the mask unchanged.
- R4: A trigger-address (bus_addr 2) write loads the trigger selector, which reads back at the same address. In edge mode (bit 0), a rising input sets the pending bit, which stays set until that input is acknowledged. In level mode (bit 1), the pending bit follows the input one clock later and is not cleared by acknowledge.
- R5: irq_out is high exactly when some unmasked pending input has a lower index than every set in-service bit.
- R6: During an acknowledge with irq_out high, vec_out equals base plus the index of the lowest-numbered unmasked pending input. After that clock edge, the edge-mode pending bit is cleared and, unless automatic end-of-interrupt is on, the in-service bit for that input is set.
- R7: When bit 1 of the mode word is 1, an acknowledge leaves the in-service register unchanged.
- R8: A command write of 0x60+n (n = 0..7) clears in-service bit n and no other bit.
- R9: Command write 0x0A selects the pending register and 0x0B selects the in-service register for command-address reads.
- R10: An acknowledge while irq_out is low returns base+7, even when input 7 is masked, and changes neither the pending nor the in-service register.
- R11: The second initialization word appears on cascade_cfg from the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_in | input | 8 | Interrupt request lines, index 0 most urgent |
| bus_addr | input | 2 | 0 command, 1 data/mask, 2 trigger selector, 3 unused (reads 0) |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| ack | input | 1 | Interrupt acknowledge pulse |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector, valid while ack is high |
| cascade_cfg | output | 8 | Stored cascade configuration word |

## Verification
The assertions check the following on every cycle: irq_out never rises without an unmasked pending bit; an end-of-interrupt leaves its bit clear; an automatic or spurious acknowledge leaves the in-service register untouched; a mask write lands; and a normal acknowledge sets the served bit. The bench scenarios are what show that the vector arithmetic is right. They also show that the priority order holds over every request pattern and every mask pattern, that the in-service blocking and the edge latching of a pulse work, and that the short and long initialization sequences steer the data writes correctly.

// File: rtl/pic_pkg.sv
// Shared constants and types for the interrupt controller.
// Assumes an 8-bit register port and command codes fixed by software convention.
package pic_pkg;
    localparam int DW = 8;

    typedef enum logic [1:0] {
        CFG_READY = 2'd0,
        CFG_BASE  = 2'd1,
        CFG_CASC  = 2'd2,
        CFG_MODE  = 2'd3
    } cfg_state_e;

    localparam logic [1:0] ADDR_CMD  = 2'd0;
    localparam logic [1:0] ADDR_DATA = 2'd1;
    localparam logic [1:0] ADDR_TRIG = 2'd2;

    localparam logic [7:0] CMD_SEL_PEND = 8'h0A;
    localparam logic [7:0] CMD_SEL_ISR  = 8'h0B;
    localparam logic [4:0] CMD_EOI_TAG  = 5'b01100;
endpackage

// File: rtl/pic_regs.sv
// Register port: initialization word sequencer, mask, base, cascade word,
// mode, readback select, trigger selector and end-of-interrupt decode.
// Assumes at most one write per cycle and N_IN <= 8.
module pic_regs
    import pic_pkg::*;
#(
    parameter int N_IN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      bus_addr,
    input  logic            bus_wr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [N_IN-1:0] mask_q,
    output logic [DW-1:0]   base_q,
    output logic [DW-1:0]   casc_q,
    output logic            aeoi_q,
    output logic            rd_isr_q,
    output logic [N_IN-1:0] trig_q,
    output logic [N_IN-1:0] eoi_clr,
    output logic            init_start
);
    cfg_state_e state_q;
    logic       want_mode_q;
    logic       cmd_wr, data_wr;

    assign cmd_wr     = bus_wr && (bus_addr == ADDR_CMD);
    assign data_wr    = bus_wr && (bus_addr == ADDR_DATA);
    assign init_start = cmd_wr && bus_wdata[4];

    // Decode a numbered end-of-interrupt into a one-hot clear vector.
    always_comb begin
        eoi_clr = '0;
        if (cmd_wr && (bus_wdata[7:3] == CMD_EOI_TAG)) begin
            for (int i = 0; i < N_IN; i++)
                if (bus_wdata[2:0] == 3'(i)) eoi_clr[i] = 1'b1;
        end
    end

    // Initialization sequencer and configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= CFG_READY;
            want_mode_q <= 1'b0;
            mask_q      <= '1;
            base_q      <= '0;
            casc_q      <= '0;
            aeoi_q      <= 1'b0;
            rd_isr_q    <= 1'b0;
        end else if (init_start) begin
            state_q     <= CFG_BASE;
            want_mode_q <= bus_wdata[0];
            aeoi_q      <= 1'b0;
            rd_isr_q    <= 1'b0;
        end else if (cmd_wr) begin
            if (bus_wdata == CMD_SEL_PEND)     rd_isr_q <= 1'b0;
            else if (bus_wdata == CMD_SEL_ISR) rd_isr_q <= 1'b1;
        end else if (data_wr) begin
            case (state_q)
                CFG_BASE: begin
                    base_q  <= bus_wdata;
                    state_q <= CFG_CASC;
                end
                CFG_CASC: begin
                    casc_q  <= bus_wdata;
                    state_q <= want_mode_q ? CFG_MODE : CFG_READY;
                end
                CFG_MODE: begin
                    aeoi_q  <= bus_wdata[1];
                    state_q <= CFG_READY;
                end
                default: mask_q <= bus_wdata[N_IN-1:0];
            endcase
        end
    end

    // Per-input edge/level selector.
    always_ff @(posedge clk) begin
        if (!rst_n)
            trig_q <= '0;
        else if (bus_wr && (bus_addr == ADDR_TRIG))
            trig_q <= bus_wdata[N_IN-1:0];
    end

    a_r3_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && state_q == CFG_READY) |=> (mask_q == $past(bus_wdata[N_IN-1:0])));
    a_r2_init_enters_base: assert property (@(posedge clk) disable iff (!rst_n)
        init_start |=> (state_q == CFG_BASE && !aeoi_q));
    a_r1_reset_mask: assert property (@(posedge clk)
        !rst_n |=> (mask_q == '1 && trig_q == '0));
endmodule

// File: rtl/pic_pend.sv
// Pending-request register, one bit per input, edge or level sensed.
// Assumes req_in is already synchronous to clk.
module pic_pend #(
    parameter int N_IN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] req_in,
    input  logic [N_IN-1:0] lvl_sel,
    input  logic [N_IN-1:0] ack_clr,
    output logic [N_IN-1:0] pend_q
);
    logic [N_IN-1:0] req_d;

    for (genvar g = 0; g < N_IN; g++) begin : g_bit
        // Sample the line for edge detection and update the pending bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                req_d[g]  <= 1'b0;
                pend_q[g] <= 1'b0;
            end else begin
                req_d[g] <= req_in[g];
                if (lvl_sel[g])
                    pend_q[g] <= req_in[g];
                else
                    pend_q[g] <= (pend_q[g] & ~ack_clr[g]) | (req_in[g] & ~req_d[g]);
            end
        end

        a_r4_level_tracks: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl_sel[g] && $past(rst_n)) |-> ##0 1'b1 ##1 (pend_q[g] == $past(req_in[g]) || !$past(lvl_sel[g])));
    end
endmodule

// File: rtl/pic_prio.sv
// Fixed-priority resolver: lowest unmasked pending index wins if it is more
// urgent than every in-service input. Purely combinational.
module pic_prio #(
    parameter int N_IN  = 8,
    parameter int IDX_W = $clog2(N_IN)
) (
    input  logic [N_IN-1:0]  pend,
    input  logic [N_IN-1:0]  mask,
    input  logic [N_IN-1:0]  isr,
    output logic             present,
    output logic [IDX_W-1:0] win
);
    logic [N_IN-1:0] cand;
    logic            found;
    logic [IDX_W:0]  svc_lvl;

    // Scan for the winning request and the most urgent in-service level.
    always_comb begin
        cand    = pend & ~mask;
        win     = '0;
        found   = 1'b0;
        svc_lvl = (IDX_W+1)'(N_IN);
        for (int i = N_IN - 1; i >= 0; i--) begin
            if (cand[i]) begin
                win   = IDX_W'(i);
                found = 1'b1;
            end
            if (isr[i]) svc_lvl = (IDX_W+1)'(i);
        end
        present = found && ({1'b0, win} < svc_lvl);
    end
endmodule

// File: rtl/pic_ctrl.sv
// Eight-input vectored interrupt controller top: in-service register,
// acknowledge handling, vector generation and register readback.
// Assumes ack is a single-cycle pulse and vec_out is sampled during it.
module pic_ctrl
    import pic_pkg::*;
#(
    parameter int N_IN  = 8,
    localparam int IDX_W = $clog2(N_IN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N_IN-1:0] req_in,
    input  logic [1:0]    bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          ack,
    output logic          irq_out,
    output logic [DW-1:0] vec_out,
    output logic [DW-1:0] cascade_cfg
);
    logic [N_IN-1:0]  mask_q, trig_q, eoi_clr, pend_q, isr_q;
    logic [N_IN-1:0]  win_hot, pend_clr, isr_set;
    logic [DW-1:0]    base_q;
    logic             aeoi_q, rd_isr_q, init_start, present;
    logic [IDX_W-1:0] win;

    pic_regs #(.N_IN(N_IN)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .mask_q(mask_q), .base_q(base_q),
        .casc_q(cascade_cfg), .aeoi_q(aeoi_q), .rd_isr_q(rd_isr_q),
        .trig_q(trig_q), .eoi_clr(eoi_clr), .init_start(init_start)
    );

    pic_pend #(.N_IN(N_IN)) u_pend (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .lvl_sel(trig_q),
        .ack_clr(pend_clr), .pend_q(pend_q)
    );

    pic_prio #(.N_IN(N_IN)) u_prio (
        .pend(pend_q), .mask(mask_q), .isr(isr_q), .present(present), .win(win)
    );

    // One-hot of the winner and the acknowledge side effects.
    always_comb begin
        win_hot = '0;
        win_hot[win] = 1'b1;
        pend_clr = (ack && present) ? win_hot : '0;
        isr_set  = (ack && present && !aeoi_q) ? win_hot : '0;
    end

    // In-service register: set on normal acknowledge, cleared by EOI or init.
    always_ff @(posedge clk) begin
        if (!rst_n)         isr_q <= '0;
        else if (init_start) isr_q <= '0;
        else                 isr_q <= (isr_q & ~eoi_clr) | isr_set;
    end

    assign irq_out = present;
    assign vec_out = present ? (base_q + DW'(win)) : (base_q + DW'(N_IN - 1));

    // Readback multiplexer.
    always_comb begin
        case (bus_addr)
            ADDR_CMD:  bus_rdata = DW'(rd_isr_q ? isr_q : pend_q);
            ADDR_DATA: bus_rdata = DW'(mask_q);
            ADDR_TRIG: bus_rdata = DW'(trig_q);
            default:   bus_rdata = '0;
        endcase
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (isr_q == '0 && pend_q == '0));
    a_r5_irq_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((pend_q & ~mask_q) != '0));
    a_r6_isr_set: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_out && !aeoi_q && !init_start) |=> isr_q[$past(win)]);
    a_r7_aeoi_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && aeoi_q && eoi_clr == '0 && !init_start) |=> (isr_q == $past(isr_q)));
    a_r8_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_clr != '0 && !ack) |=> ((isr_q & $past(eoi_clr)) == '0));
    a_r10_spurious_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !irq_out && eoi_clr == '0 && !init_start) |=> (isr_q == $past(isr_q)));
endmodule

// File: tb/pic_ctrl_tb.sv
`timescale 1ns/1ps
module pic_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_in = '0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ack = 1'b0;
    logic       irq_out;
    logic [7:0] vec_out;
    logic [7:0] cascade_cfg;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] got;
    logic [7:0] base;

    pic_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ack(ack), .irq_out(irq_out), .vec_out(vec_out), .cascade_cfg(cascade_cfg)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic do_ack(output logic [7:0] v);
        @(negedge clk);
        ack = 1'b1;
        #1 v = vec_out;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic init_seq(input logic [7:0] w1, input logic [7:0] b,
                            input logic [7:0] c, input logic [7:0] m);
        wr(2'd0, w1);
        wr(2'd1, b);
        wr(2'd1, c);
        if (w1[0]) wr(2'd1, m);
        base = b;
    endtask

    function automatic int lowest(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) if (v[i]) lowest = i;
    endfunction

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1 check("R1 irq", {7'd0, irq_out}, 8'h00);
        rd(2'd0, got); check("R1 pending", got, 8'h00);
        rd(2'd1, got); check("R1 mask", got, 8'hFF);
        rd(2'd2, got); check("R1 trig", got, 8'h00);
        wr(2'd0, 8'h0B);
        rd(2'd0, got); check("R1 isr", got, 8'h00);
        wr(2'd0, 8'h0A);

        // R2/R11/R3: long init leaves mask, stores cascade word
        init_seq(8'h11, 8'h20, 8'h04, 8'h01);
        #1 check("R11 cascade", cascade_cfg, 8'h04);
        rd(2'd1, got); check("R3 mask kept by init", got, 8'hFF);
        wr(2'd1, 8'h00);
        rd(2'd1, got); check("R3 mask load", got, 8'h00);

        // R4/R6/R8/R9: edge sweep over every input
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); req_in = 8'(1 << i);
            @(negedge clk); req_in = '0;
            @(negedge clk);
            check("R5 edge irq", {7'd0, irq_out}, 8'h01);
            rd(2'd0, got); check("R4 edge latched", got, 8'(1 << i));
            do_ack(got); check("R6 vector", got, 8'(8'h20 + i));
            rd(2'd0, got); check("R4 cleared by ack", got, 8'h00);
            wr(2'd0, 8'h0B);
            rd(2'd0, got); check("R9 isr readback", got, 8'(1 << i));
            wr(2'd0, 8'(8'h60 + i));
            rd(2'd0, got); check("R8 eoi", got, 8'h00);
            wr(2'd0, 8'h0A);
        end

        // R4/R5/R6: exhaustive level request patterns
        wr(2'd2, 8'hFF);
        rd(2'd2, got); check("R4 trig readback", got, 8'hFF);
        for (int p = 0; p < 256; p++) begin
            @(negedge clk); req_in = 8'(p);
            @(negedge clk);
            check("R5 any request", {7'd0, irq_out}, (p != 0) ? 8'h01 : 8'h00);
            if (p != 0) begin
                do_ack(got); check("R6 lowest wins", got, 8'(8'h20 + lowest(8'(p))));
                #1 check("R5 blocked by isr", {7'd0, irq_out}, 8'h00);
                rd(2'd0, got); check("R4 level not cleared", got, 8'(p));
                wr(2'd0, 8'(8'h60 + lowest(8'(p))));
            end
        end
        @(negedge clk); req_in = '0;

        // R3/R5: exhaustive mask patterns with all inputs requesting
        @(negedge clk); req_in = 8'hFF;
        for (int m = 0; m < 256; m++) begin
            wr(2'd1, 8'(m));
            #1 check("R3 mask blocks", {7'd0, irq_out}, (m != 255) ? 8'h01 : 8'h00);
            if (m != 255) begin
                do_ack(got); check("R3 unmasked vector", got, 8'(8'h20 + lowest(~8'(m))));
                wr(2'd0, 8'(8'h60 + lowest(~8'(m))));
            end
        end
        wr(2'd1, 8'h00);
        @(negedge clk); req_in = '0;

        // R5/R8: nesting, a more urgent input preempts; EOI clears one bit only
        @(negedge clk); req_in = 8'h08;
        @(negedge clk); do_ack(got); check("R6 nest outer", got, 8'h23);
        @(negedge clk); req_in = 8'h28;
        @(negedge clk); #1 check("R5 less urgent blocked", {7'd0, irq_out}, 8'h00);
        req_in = 8'h0A;
        @(negedge clk); #1 check("R5 more urgent passes", {7'd0, irq_out}, 8'h01);
        do_ack(got); check("R6 nest inner", got, 8'h21);
        wr(2'd0, 8'h0B);
        rd(2'd0, got); check("R6 two in service", got, 8'h0A);
        wr(2'd0, 8'h63);
        rd(2'd0, got); check("R8 only bit 3", got, 8'h02);
        wr(2'd0, 8'h61);
        rd(2'd0, got); check("R8 all clear", got, 8'h00);
        wr(2'd0, 8'h0A);
        @(negedge clk); req_in = '0;

        // R10: spurious acknowledge, then with input 7 masked
        @(negedge clk); req_in = 8'h10;
        @(negedge clk); req_in = '0;
        @(negedge clk); #1 check("R10 request gone", {7'd0, irq_out}, 8'h00);
        do_ack(got); check("R10 spurious vector", got, 8'h27);
        wr(2'd0, 8'h0B);
        rd(2'd0, got); check("R10 no isr", got, 8'h00);
        wr(2'd1, 8'h80);
        do_ack(got); check("R10 spurious masked 7", got, 8'h27);
        rd(2'd0, got); check("R10 no isr masked", got, 8'h00);
        wr(2'd1, 8'h00);

        // R2/R7: re-init with automatic EOI; init reselects pending readback
        @(negedge clk); req_in = 8'h20;
        init_seq(8'h11, 8'h40, 8'h07, 8'h03);
        rd(2'd0, got); check("R2 pending readback", got, 8'h20);
        #1 check("R11 cascade new", cascade_cfg, 8'h07);
        do_ack(got); check("R7 vector", got, 8'h45);
        wr(2'd0, 8'h0B);
        rd(2'd0, got); check("R7 no isr", got, 8'h00);
        @(negedge clk); req_in = '0;

        // R2: short init, third data write is the mask, normal EOI mode
        init_seq(8'h10, 8'h60, 8'h04, 8'h00);
        wr(2'd1, 8'h55);
        rd(2'd1, got); check("R2 short init mask", got, 8'h55);
        @(negedge clk); req_in = 8'h02;
        @(negedge clk); do_ack(got); check("R2 new base", got, 8'h61);
        wr(2'd0, 8'h0B);
        rd(2'd0, got); check("R2 aeoi off", got, 8'h02);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule